// File: doc/BRIEF.md
# Selectable Baud Tick Generator

This block turns a fixed system clock into the two timing strobes a serial
port needs. A 3-bit rate code picks one of eight standard bit rates. For the
chosen rate the block gives a one-cycle strobe at sixteen times the bit rate,
so a receiver can find the start edge and then sample each bit near its
middle. It also gives a one-cycle strobe once per bit period, which a
transmitter uses to shift out bits that all last the same time.

Each divisor is computed at elaboration from the clock frequency parameter.
The divisor is the clock frequency divided by sixteen times the rate, rounded
to the nearest integer. A synchronous reset clears the counters and makes 9600
bit/s the current rate. Any later change of the rate code restarts the timing
from zero. The first strobe at the new rate therefore comes one whole period
after the change.

Top module: `baud_tick_gen`

## Requirements
- R1: Rate code 0 selects 600 bit/s, 1 selects 1200, 2 selects 2400, 3 selects 4800, 4 selects 9600, 5 selects 14400, 6 selects 19200 and 7 selects 38400. The divisor D for a rate is round(CLK_HZ / (16 × rate)); with CLK_HZ = 1 MHz the divisors for codes 0 to 7 are 104, 52, 26, 13, 7, 4, 3, 2.
- R2: `os_tick` is high for exactly one cycle, and at a steady rate code it rises once every D clock cycles.
- R3: `bit_tick` is high for one cycle on every 16th `os_tick`, always in the same cycle as that `os_tick`, so the bit period is 16 × D cycles.
- R4: While `rst` is high, both strobes stay low and both counters are held at zero.
- R5: After reset the current rate code is 4 (9600 bit/s). With the input at code 4 when reset is released, the first `os_tick` is seen in the cycle after the (D−1)th rising edge with `rst` low.
- R6: A rate code that differs from the current one is taken at the next clock edge, and that edge clears both counters. The first `os_tick` at the new rate follows D cycles after that edge, and the first `bit_tick` follows 16 × D cycles after it. A change that is undone before a period ends produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Rate code, see R1 |
| os_tick | output | 1 | One-cycle strobe at 16 × bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
Two functions can fall in the same cycle: the 16th oversample strobe and the
bit strobe. The bench provokes this at every rate by switching the code and
counting cycles up to the bit strobe. It then checks that the bit strobe comes
exactly 16 × D cycles after the switch and that it is the 16th oversample
strobe, seen in the same sampled cycle. Restarts after a code change and after
reset are also checked: the bench counts cycles from the edge that cleared the
counters.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned OVS    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_sel,
  output logic       os_tick,
  output logic       bit_tick
);

  function automatic int unsigned rate_of(input logic [2:0] s);
    case (s)
      3'd0:    return 600;
      3'd1:    return 1200;
      3'd2:    return 2400;
      3'd3:    return 4800;
      3'd4:    return 9600;
      3'd5:    return 14400;
      3'd6:    return 19200;
      default: return 38400;
    endcase
  endfunction

  function automatic int unsigned div_of(input logic [2:0] s);
    return (CLK_HZ + rate_of(s) * OVS / 2) / (rate_of(s) * OVS);
  endfunction

  localparam int unsigned DMAX = div_of(3'd0);
  localparam int CW = $clog2(DMAX + 1);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [2:0] SEL_RST = 3'd4;

  logic [CW-1:0] cnt, lim;
  logic [SW-1:0] sub;
  logic [2:0]    sel_q;
  logic          same, wrap;

  assign lim  = CW'(div_of(sel_q) - 1);
  assign same = (rate_sel == sel_q);
  assign wrap = (cnt == lim);

  assign os_tick  = !rst && same && wrap;
  assign bit_tick = os_tick && (sub == SW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sub   <= '0;
      sel_q <= SEL_RST;
    end else if (!same) begin
      cnt   <= '0;
      sub   <= '0;
      sel_q <= rate_sel;
    end else if (wrap) begin
      cnt <= '0;
      sub <= (sub == SW'(OVS - 1)) ? '0 : sub + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      // R1
      div_min_chk: assert (div_of(3'(s)) >= 2);
    end
  end

  // R2
  os_gap_chk: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

  // R3
  sub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!os_tick && rate_sel == sel_q) |=> (sub == $past(sub)));

  // R4
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!os_tick && !bit_tick));

  // R6
  sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_sel != sel_q) |=> !os_tick);

endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ = 1_000_000;
  localparam int NV = 8;
  localparam int SEL_T [NV] = '{0, 1, 2, 3, 5, 6, 7, 4};
  localparam int DIV_T [NV] = '{104, 52, 26, 13, 4, 3, 2, 7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rate_sel = 3'd4;
  logic os_tick, bit_tick;
  int total = 0, bad = 0;
  int cycles = 0;

  baud_tick_gen #(.CLK_HZ(HZ)) i_baud_tick_gen (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .os_tick(os_tick), .bit_tick(bit_tick));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // counts negedge samples until os_tick, limit lim
  task automatic wait_os(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!os_tick && n < lim);
  endtask

  initial begin
    int n, nos, first, second, nbit, spur, wide;
    // R4: ticks stay low during reset
    spur = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) spur++;
    end
    check("R4 strobes during reset", spur, 0);

    // R5: default code 4, first tick D-1 samples after release
    rst = 1'b0;
    wait_os(n, 5000);
    check("R5 first os_tick after reset at default rate", n, 6);

    // R1 R2 R3 R6: walk the rate table
    for (int v = 0; v < NV; v++) begin
      rate_sel = 3'(SEL_T[v]);
      n = 0; nos = 0; first = 0; second = 0; nbit = 0; spur = 0; wide = 0;
      while (nbit == 0 && n < 5000) begin
        @(negedge clk);
        n++;
        if (bit_tick && !os_tick) spur++;
        if (os_tick) begin
          nos++;
          if (nos == 1) first = n;
          if (nos == 2) second = n;
          if (n == first + 1 && nos > 1) wide++;
        end
        if (bit_tick) nbit = n;
      end
      check($sformatf("R6 first os_tick code %0d", SEL_T[v]), first, DIV_T[v]);
      check($sformatf("R1 os period code %0d", SEL_T[v]), second - first, DIV_T[v]);
      check($sformatf("R3 first bit_tick code %0d", SEL_T[v]), nbit, 16 * DIV_T[v]);
      check($sformatf("R3 os count at bit_tick code %0d", SEL_T[v]), nos, 16);
      check($sformatf("R3 bit_tick without os_tick code %0d", SEL_T[v]), spur, 0);
      check($sformatf("R2 os_tick width code %0d", SEL_T[v]), wide, 0);
      @(negedge clk);
      check($sformatf("R3 bit_tick one cycle code %0d", SEL_T[v]), int'(bit_tick), 0);
    end

    // R6: change undone before a period ends gives no strobe
    rate_sel = 3'd0;
    spur = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (os_tick) spur++;
    end
    check("R6 no strobe in aborted slow period", spur, 0);
    rate_sel = 3'd4;
    wait_os(n, 5000);
    check("R6 restart after undo", n, 7);

    // R4 R6: reset with a non-default code, first edge switches rate
    rst = 1'b1;
    rate_sel = 3'd1;
    spur = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) spur++;
    end
    check("R4 strobes during second reset", spur, 0);
    rst = 1'b0;
    wait_os(n, 5000);
    check("R6 first os_tick after reset with code 1", n, 52);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule